// File: doc/BRIEF.md
# Watchdog with timed-unlock configuration

A watchdog timer whose control register guards its enable and timeout-period fields behind a two-step timed write. Software first writes an unlock value. It then has a short, fixed window in which a second write may change the protected fields. Outside that window, writes that would weaken the watchdog or change its period are dropped. A static protection-level pin selects how strict the rules are. At the soft level the watchdog starts stopped and may be switched on freely. At the hard level it always runs, and only its period can be changed, through the same unlock steps.

The counter advances once per clock while the watchdog runs. A kick input clears it. When it reaches the limit set by the period field, the block emits a one-cycle timeout pulse and starts counting again. The register port is a single-cycle write strobe with 8-bit data and a continuous 8-bit read-back. All pins are plain control and status with no handshake, because no data stream passes through the block.

Register layout, used for both write and read: bit 4 `UNL` (unlock request on write, window-open flag on read), bit 3 `RUN` (enable), bits 2:0 `PSEL` (period select), bits 7:5 ignored on write and read as zero.

Top module: `wdt_lockcfg`

## Requirements
- R1: With `prot_lvl`=0, reset leaves the register reading 0x00: stopped, period 0, window closed, and no timeout pulse.
- R2: With `prot_lvl`=0, any write with bit 3 set turns the watchdog on at once, with no sequence needed.
- R3: A write with bits 4 and 3 both set is an unlock write and opens the window. While the window is open, bit 4 reads 1. Bits 7:5 always read 0.
- R4: A write with bit 4 clear on any of the four clock edges after an unlock write loads bit 3 (level 0 only) and bits 2:0, then closes the window.
- R5: While the window is closed, writes that clear bit 3 or carry a new bits 2:0 leave those fields unchanged.
- R6: The window closes by itself after four edges with no write, and bit 4 then reads 0. A data write on the fifth edge is ignored.
- R7: An unlock write made while the window is open restarts the four-edge window and changes neither bit 3 nor bits 2:0.
- R8: With `prot_lvl`=1, bit 3 always reads 1, counting starts straight out of reset, and no write can stop it.
- R9: With `prot_lvl`=1, the unlock steps change only bits 2:0. The bit 3 value in the data write is ignored.
- R10: `kick` high on an edge clears the count, so the next timeout comes 2^(BASE_LOG+PSEL) edges after that edge.
- R11: A running watchdog pulses `tmo_pulse` high for one cycle, 2^(BASE_LOG+PSEL) edges after the count started, and repeats with that spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_lvl | input | 1 | Static protection level: 0 soft, 1 hard |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write data |
| kick | input | 1 | Clears the timeout count |
| rd_data | output | 8 | Register read-back |
| tmo_pulse | output | 1 | One-cycle timeout pulse |

## Verification
The hardest cases to reach from the pins are the edges of the unlock window. A data write on the fourth edge after unlocking must be taken, and the same write on the fifth edge must be dropped. A second unlock must push the deadline out without applying its own field bits. The stimulus counts clock edges from a free-running bench counter and places each write on an exact edge number. Writes are positioned relative to the first unlock at distances that only pass if the restart really happened. The bench also predicts the edge of every timeout pulse from the enable, kick and period-change edges, so any change in counting or window timing shows up as a pulse on the wrong edge.

// File: rtl/wdt_lock_pkg.sv
package wdt_lock_pkg;
  localparam int REG_W  = 8;
  localparam int PSEL_W = 3;
  localparam int BIT_UNL = 4;
  localparam int BIT_RUN = 3;

  typedef enum logic {
    LVL_SOFT = 1'b0,
    LVL_HARD = 1'b1
  } prot_e;

  typedef struct packed {
    logic              run;
    logic [PSEL_W-1:0] psel;
  } cfg_t;
endpackage

// File: rtl/wdt_unlock_win.sv
module wdt_unlock_win #(
  parameter int WIN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic take_i,
  output logic open_o
);
  localparam int WC_W = $clog2(WIN_LEN + 1);

  logic [WC_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= '0;
    else if (arm_i)
      left_q <= WC_W'(WIN_LEN);
    else if (take_i)
      left_q <= '0;
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign open_o = (left_q != '0);
endmodule

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_lock_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prot_lvl,
  input  logic            wr_en,
  input  logic [BIT_UNL:0] wr_low,
  input  logic            win_open,
  output logic            arm_o,
  output logic            take_o,
  output cfg_t            cfg_o
);
  prot_e lvl;
  cfg_t  cfg_q;
  logic  unl_bit, run_bit;

  assign lvl     = prot_e'(prot_lvl);
  assign unl_bit = wr_low[BIT_UNL];
  assign run_bit = wr_low[BIT_RUN];
  assign arm_o   = wr_en && unl_bit && run_bit;
  assign take_o  = wr_en && !unl_bit && win_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (take_o) begin
      cfg_q.psel <= wr_low[PSEL_W-1:0];
      if (lvl == LVL_SOFT)
        cfg_q.run <= run_bit;
    end else if (wr_en && run_bit && lvl == LVL_SOFT) begin
      cfg_q.run <= 1'b1;
    end
  end

  always_comb begin
    cfg_o     = cfg_q;
    cfg_o.run = cfg_q.run || (lvl == LVL_HARD);
  end
endmodule

// File: rtl/wdt_tick_count.sv
module wdt_tick_count #(
  parameter int BASE_LOG = 10,
  parameter int PSEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              kick_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tmo_o
);
  localparam int MAXSH = (1 << PSEL_W) - 1;
  localparam int CNT_W = BASE_LOG + MAXSH;

  logic [CNT_W-1:0]  cnt_q, lim;
  logic [PSEL_W-1:0] sh;
  logic              hit;

  assign sh  = PSEL_W'(MAXSH) - psel_i;
  assign lim = {CNT_W{1'b1}} >> sh;
  assign hit = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i || kick_i) begin
      cnt_q <= '0;
      tmo_o <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      tmo_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tmo_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_lockcfg.sv
module wdt_lockcfg
  import wdt_lock_pkg::*;
#(
  parameter int BASE_LOG = 10,
  parameter int WIN_LEN  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_lvl,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             kick,
  output logic [REG_W-1:0] rd_data,
  output logic             tmo_pulse
);
  logic arm, take, win_open;
  cfg_t cfg;
  logic unused_rsv;

  assign unused_rsv = ^wr_data[REG_W-1:BIT_UNL+1];

  wdt_unlock_win #(.WIN_LEN(WIN_LEN)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (arm),
    .take_i (take),
    .open_o (win_open)
  );

  wdt_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .prot_lvl (prot_lvl),
    .wr_en    (wr_en),
    .wr_low   (wr_data[BIT_UNL:0]),
    .win_open (win_open),
    .arm_o    (arm),
    .take_o   (take),
    .cfg_o    (cfg)
  );

  wdt_tick_count #(.BASE_LOG(BASE_LOG), .PSEL_W(PSEL_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (cfg.run),
    .kick_i (kick),
    .psel_i (cfg.psel),
    .tmo_o  (tmo_pulse)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_UNL] = win_open;
    rd_data[BIT_RUN] = cfg.run;
    rd_data[PSEL_W-1:0] = cfg.psel;
  end
endmodule

// File: rtl/wdt_lockcfg_checker.sv
module wdt_lockcfg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       prot_lvl,
  input logic       wr_en,
  input logic [7:0] rd_data,
  input logic       tmo_pulse
);
  logic [2:0] quiet_age;

  always_ff @(posedge clk) begin
    if (!rst_n || wr_en || !rd_data[4])
      quiet_age <= '0;
    else if (quiet_age != 3'd7)
      quiet_age <= quiet_age + 1'b1;
  end

  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);

  assert_window_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> quiet_age < 3'd4);

  assert_psel_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data[2:0]) |-> $past(rd_data[4] && wr_en));

  assert_run_clear_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[3]) |-> $past(rd_data[4] && wr_en));

  assert_hard_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prot_lvl |-> rd_data[3]);

  assert_tmo_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse);

  assert_tmo_needs_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> $past(rd_data[3]));
endmodule

bind wdt_lockcfg wdt_lockcfg_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prot_lvl  (prot_lvl),
  .wr_en     (wr_en),
  .rd_data   (rd_data),
  .tmo_pulse (tmo_pulse)
);

// File: tb/wdt_lockcfg_bench.sv
`timescale 1ns/1ps
module wdt_lockcfg_bench;
  localparam int BL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prot_lvl = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       kick = 1'b0;
  logic [7:0] rd_data;
  logic       tmo_pulse;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int exp_q[$];
  logic done = 1'b0;

  wdt_lockcfg #(.BASE_LOG(BL), .WIN_LEN(4)) u_wdt_lockcfg (
    .clk(clk), .rst_n(rst_n), .prot_lvl(prot_lvl), .wr_en(wr_en),
    .wr_data(wr_data), .kick(kick), .rd_data(rd_data), .tmo_pulse(tmo_pulse)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every pulse must match the next predicted edge
  always @(negedge clk) begin
    if (rst_n && tmo_pulse) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R11 unexpected pulse at edge %0d expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          n_err++;
          $display("FAIL R11/R10 pulse at edge %0d expected %0d", cyc, e);
        end
      end
    end
  end

  function automatic int per_len(input int p);
    return 1 << (BL + p);
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); wr_en = 1'b0; kick = 1'b0;
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic k, output int t);
    @(negedge clk); wr_en = 1'b1; wr_data = d; kick = k;
    @(posedge clk); #1 t = cyc;
  endtask

  task automatic kick_at(output int t);
    @(negedge clk); wr_en = 1'b0; kick = 1'b1;
    @(posedge clk); #1 t = cyc;
  endtask

  task automatic wait_edge(input int t);
    while (cyc + 1 < t) begin
      @(negedge clk); wr_en = 1'b0; kick = 1'b0;
    end
  endtask

  task automatic chk(input logic [7:0] exp, input string tag);
    @(negedge clk); wr_en = 1'b0; kick = 1'b0;
    n_chk++;
    if (rd_data !== exp) begin
      n_err++;
      $display("FAIL %s rd_data=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      foreach (exp_q[i]) begin
        n_chk++; n_err++;
        $display("FAIL R11 missing pulse actual none expected edge %0d", exp_q[i]);
      end
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual hung expected finish");
    finish_run();
  end

  initial begin
    int c0, e1, ue, u, d, r0, k, t;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    chk(8'h00, "R1 reset state");
    idle(20);

    // R2: free enable, then R5 ignored clears/period changes
    wr(8'h08, 1'b0, c0);
    exp_q.push_back(c0 + per_len(0));
    exp_q.push_back(c0 + 2 * per_len(0));
    chk(8'h08, "R2 free enable");
    wr(8'h00, 1'b0, t);
    chk(8'h08, "R5 clear without sequence ignored");
    wr(8'h03, 1'b0, t);
    chk(8'h08, "R5 period without sequence ignored");

    // R3/R4: unlock then disable
    wait_edge(c0 + 19);
    wr(8'h18, 1'b0, t);
    chk(8'h18, "R3 window flag open");
    wr(8'h00, 1'b0, t);
    chk(8'h00, "R4 sequence disables");

    // R6: late data write
    wait_edge(c0 + 25);
    wr(8'h08, 1'b0, e1);
    exp_q.push_back(e1 + per_len(0));
    wr(8'h18, 1'b0, t);
    idle(4);
    wr(8'h05, 1'b0, t);
    chk(8'h08, "R6 window expired, fifth edge ignored");

    // R4 boundary: data on fourth edge, with kick
    wait_edge(e1 + 9);
    wr(8'h18, 1'b0, ue);
    idle(3);
    wr(8'h0D, 1'b1, t);
    exp_q.push_back(t + per_len(5));
    exp_q.push_back(t + 2 * per_len(5));
    chk(8'h0D, "R4 fourth edge accepted");

    // R7: restart
    wait_edge(t + 2 * per_len(5) + 8);
    wr(8'h18, 1'b0, u);
    idle(3);
    wr(8'h18, 1'b0, t);
    chk(8'h1D, "R7 restart keeps fields");
    idle(2);
    wr(8'h0A, 1'b1, t);
    exp_q.push_back(t + per_len(2));
    chk(8'h0A, "R7 restarted window accepts");
    wait_edge(t + per_len(2) + 3);
    wr(8'h18, 1'b0, d);
    wr(8'h00, 1'b0, d);
    chk(8'h00, "R4 disable again");
    idle(10);

    // hard level
    @(negedge clk); rst_n = 1'b0; prot_lvl = 1'b1;
    idle(3);
    @(negedge clk); rst_n = 1'b1; r0 = cyc;
    exp_q.push_back(r0 + per_len(0));
    chk(8'h08, "R8 runs from reset");
    wait_edge(r0 + 3);
    wr(8'h00, 1'b0, t);
    chk(8'h08, "R8 cannot be stopped");
    wait_edge(r0 + 10);
    wr(8'h18, 1'b0, t);
    wr(8'h02, 1'b1, t);
    exp_q.push_back(t + per_len(2));
    chk(8'h0A, "R9 period changed, enable ignored");
    wait_edge(t + per_len(2) + 10);
    kick_at(k);
    exp_q.push_back(k + per_len(2));
    wr(8'h07, 1'b0, t);
    chk(8'h0A, "R9 period locked outside window");
    wait_edge(k + per_len(2) + 5);
    idle(1);
    finish_run();
  end
endmodule